// File: doc/BRIEF.md
# Express Virtual Channel Bypass Control

This block governs one output direction of a router that carries express virtual channels: channels held across a run of consecutive routers. It sits between the incoming flit stream for that direction and the switch-traversal stage. It decides cycle by cycle whether a flit goes straight to traversal or waits in a small input queue for the ordinary allocators.

A static configuration input sets the router's role for the express channel. When the router is an intermediate hop, an express flit does not go through VC allocation or switch allocation and is never written into the queue. It moves to switch traversal on the next cycle. In that cycle the normal-path grant is withheld from the queue. When the router is an express endpoint, express flits are queued like normal flits and need an allocation grant. They may also leave only while a credit counter shows a free buffer at the next express endpoint. Normal flits are always queued and leave in order when the allocator grants them.

Top module: `evc_bypass_ctrl`

## Requirements
- R1: After reset `st_valid` is 0, `st_sel` is 2'b00, `alloc_req` is 0, `in_ready` is 1, and the express credit count equals `EVC_CREDITS`.
- R2: With `cfg_endpoint`=0, an accepted flit with `in_express`=1 appears on `st_data` on the cycle after acceptance, with `st_valid`=1 and `st_sel`=2'b01 (bypass). It needs no `alloc_grant` and is not queued, so it never raises `alloc_req`.
- R3: In a cycle where a bypassing flit is accepted, `alloc_req` is 0 and `alloc_grant` has no effect: the queued head stays and leaves on a later grant.
- R4: Flits that are not bypassed are queued. The head leaves only in a cycle with `alloc_req`=1 and `alloc_grant`=1. It appears on the next cycle with `st_sel`=2'b10 (buffer), and flits leave in arrival order.
- R5: While `alloc_grant` is 0, queued flits stay queued and `st_valid` stays 0 unless a bypass occurs.
- R6: With `cfg_endpoint`=1, express flits are never bypassed. They are queued and need a grant, as in R4.
- R7: With `cfg_endpoint`=1, when the queue head is express and the credit count is 0, `alloc_req` is 0 and the head does not leave.
- R8: The credit count falls by one when an express flit leaves the queue at an endpoint and rises by one on each `credit_ret` pulse. It stays at `EVC_CREDITS` at most. A departure and a return in the same cycle leave it unchanged.
- R9: Normal flits are never held back by the express credit count.
- R10: `in_ready` is 0 when the queue is full and the presented flit would be queued. It stays 1 for a flit that would be bypassed, which is then accepted even with a full queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_endpoint | input | 1 | 1: express endpoint router, 0: intermediate bypass router |
| in_valid | input | 1 | Incoming flit present |
| in_express | input | 1 | Flit belongs to the express class |
| in_data | input | FLIT_W | Flit payload |
| in_ready | output | 1 | Flit can be accepted this cycle |
| alloc_req | output | 1 | Queue head requests VC/switch allocation |
| alloc_grant | input | 1 | Allocation granted to the queue head |
| credit_ret | input | 1 | One buffer freed at the next express endpoint |
| st_valid | output | 1 | Flit on switch traversal this cycle |
| st_sel | output | 2 | 00 idle, 01 bypass path, 10 queue path |
| st_data | output | FLIT_W | Flit sent to switch traversal |

## Verification
The bench sweeps express flits through an intermediate router. A design that still queued or arbitrated them would delay them a cycle or raise `alloc_req`. It offers a grant in the same cycle as a bypass, which a missing suppression would turn into a lost queued flit. It drains express flits at an endpoint until credits run out. It also returns more credits than the counter can hold, so a counter that wraps or forgets saturation would let extra flits through. A departure coinciding with a return shows whether the counter drops a credit. The bench also fills the queue to check that a bypassing flit is still admitted.

// File: rtl/evc_byp_pkg.sv
package evc_byp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_BYPASS = 2'b01,
    ST_BUFFER = 2'b10
  } st_sel_e;
endpackage

// File: rtl/evc_flit_fifo.sv
// Input queue: data array has no reset and a registered read so it maps to RAM;
// the one-bit class flags sit in flops and are read combinationally.
module evc_flit_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wr_data,
  input  logic         wr_exp,
  input  logic         pop,
  output logic         empty,
  output logic         full,
  output logic         head_exp,
  output logic [W-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] exp_q;
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [CW-1:0]    count;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + AW'(1);
      assign rd_nxt = rd_ptr + AW'(1);
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
    end
  endgenerate

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign head_exp = exp_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
    if (pop)  rd_data     <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      exp_q  <= '0;
    end else begin
      if (push) begin
        exp_q[wr_ptr] <= wr_exp;
        wr_ptr        <= wr_nxt;
      end
      if (pop) rd_ptr <= rd_nxt;
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/evc_credit_ctr.sv
// Free-buffer count at the next express endpoint, saturating at MAX.
module evc_credit_ctr #(
  parameter int MAX = 4,
  localparam int CW = $clog2(MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          give,
  output logic          avail,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = CW'(MAX);

  assign avail = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= TOP;
    end else begin
      case ({take, give})
        2'b10:   cnt <= cnt - CW'(1);
        2'b01:   cnt <= (cnt == TOP) ? TOP : cnt + CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/evc_bypass_ctrl.sv
module evc_bypass_ctrl
  import evc_byp_pkg::*;
#(
  parameter int FLIT_W      = 32,
  parameter int BUF_DEPTH   = 8,
  parameter int EVC_CREDITS = 4,
  localparam int CRW = $clog2(EVC_CREDITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_endpoint,
  input  logic              in_valid,
  input  logic              in_express,
  input  logic [FLIT_W-1:0] in_data,
  output logic              in_ready,
  output logic              alloc_req,
  input  logic              alloc_grant,
  input  logic              credit_ret,
  output logic              st_valid,
  output logic [1:0]        st_sel,
  output logic [FLIT_W-1:0] st_data
);
  logic              byp_class, bypass_now;
  logic              fifo_push, fifo_pop, fifo_empty, fifo_full, head_exp;
  logic [FLIT_W-1:0] fifo_rd_data;
  logic              credit_avail, credit_take, head_blocked;
  logic [CRW-1:0]    credit_cnt;
  logic              st_valid_q;
  st_sel_e           sel_q;
  logic [FLIT_W-1:0] byp_data_q;

  // express flit at an intermediate hop: reserved VC, guaranteed switch
  assign byp_class  = in_express & ~cfg_endpoint;
  assign bypass_now = in_valid & byp_class;

  assign in_ready  = byp_class | ~fifo_full;
  assign fifo_push = in_valid & ~byp_class & ~fifo_full;

  assign head_blocked = head_exp & cfg_endpoint & ~credit_avail;
  assign alloc_req    = ~fifo_empty & ~head_blocked & ~bypass_now;
  assign fifo_pop     = alloc_req & alloc_grant;
  assign credit_take  = fifo_pop & head_exp & cfg_endpoint;

  evc_flit_fifo #(.W(FLIT_W), .DEPTH(BUF_DEPTH)) fifo_i (
    .clk      (clk),
    .rst      (rst),
    .push     (fifo_push),
    .wr_data  (in_data),
    .wr_exp   (in_express),
    .pop      (fifo_pop),
    .empty    (fifo_empty),
    .full     (fifo_full),
    .head_exp (head_exp),
    .rd_data  (fifo_rd_data)
  );

  evc_credit_ctr #(.MAX(EVC_CREDITS)) credit_i (
    .clk   (clk),
    .rst   (rst),
    .take  (credit_take),
    .give  (credit_ret),
    .avail (credit_avail),
    .cnt   (credit_cnt)
  );

  always_ff @(posedge clk) begin
    if (bypass_now) byp_data_q <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid_q <= 1'b0;
      sel_q      <= ST_IDLE;
    end else begin
      st_valid_q <= bypass_now | fifo_pop;
      if (bypass_now)    sel_q <= ST_BYPASS;
      else if (fifo_pop) sel_q <= ST_BUFFER;
      else               sel_q <= ST_IDLE;
    end
  end

  assign st_valid = st_valid_q;
  assign st_sel   = sel_q;
  assign st_data  = (sel_q == ST_BYPASS) ? byp_data_q : fifo_rd_data;
endmodule

// File: rtl/evc_bypass_ctrl_chk.sv
module evc_bypass_ctrl_chk #(
  parameter int FLIT_W      = 32,
  parameter int EVC_CREDITS = 4,
  localparam int CRW = $clog2(EVC_CREDITS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_endpoint,
  input logic              in_valid,
  input logic              in_express,
  input logic [FLIT_W-1:0] in_data,
  input logic              in_ready,
  input logic              alloc_req,
  input logic              alloc_grant,
  input logic              st_valid,
  input logic [1:0]        st_sel,
  input logic [FLIT_W-1:0] st_data,
  input logic              fifo_full,
  input logic              head_exp,
  input logic [CRW-1:0]    credit_cnt
);
  // R1
  idle_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !st_valid |-> st_sel == 2'b00);

  // R2
  bypass_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_express && !cfg_endpoint) |=>
      (st_valid && st_sel == 2'b01 && st_data == $past(in_data)));

  // R3
  grant_suppressed_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_express && !cfg_endpoint) |-> !alloc_req);

  // R4
  queue_departure_chk: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && alloc_grant) |=> (st_valid && st_sel == 2'b10));

  // R7
  credit_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && head_exp && cfg_endpoint) |-> credit_cnt != '0);

  // R8
  credit_bound_chk: assert property (@(posedge clk) disable iff (rst)
    credit_cnt <= CRW'(EVC_CREDITS));

  // R10
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && !(in_express && !cfg_endpoint)) |-> !in_ready);
endmodule

bind evc_bypass_ctrl evc_bypass_ctrl_chk #(
  .FLIT_W(FLIT_W), .EVC_CREDITS(EVC_CREDITS)
) chk_i (
  .clk(clk), .rst(rst), .cfg_endpoint(cfg_endpoint), .in_valid(in_valid),
  .in_express(in_express), .in_data(in_data), .in_ready(in_ready),
  .alloc_req(alloc_req), .alloc_grant(alloc_grant), .st_valid(st_valid),
  .st_sel(st_sel), .st_data(st_data), .fifo_full(fifo_full),
  .head_exp(head_exp), .credit_cnt(credit_cnt)
);

// File: tb/evc_bypass_ctrl_tb_top.sv
module evc_bypass_ctrl_tb_top;
  localparam int W = 8;
  localparam int DEPTH = 4;
  localparam int CRED = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_endpoint = 1'b0;
  logic         in_valid = 1'b0, in_express = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready, alloc_req, st_valid;
  logic         alloc_grant = 1'b0, credit_ret = 1'b0;
  logic [1:0]   st_sel;
  logic [W-1:0] st_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  evc_bypass_ctrl #(.FLIT_W(W), .BUF_DEPTH(DEPTH), .EVC_CREDITS(CRED)) dut_i (
    .clk(clk), .rst(rst), .cfg_endpoint(cfg_endpoint),
    .in_valid(in_valid), .in_express(in_express), .in_data(in_data),
    .in_ready(in_ready), .alloc_req(alloc_req), .alloc_grant(alloc_grant),
    .credit_ret(credit_ret), .st_valid(st_valid), .st_sel(st_sel),
    .st_data(st_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input bit v, input bit e, input int d, input bit g, input bit r);
    in_valid = v; in_express = e; in_data = W'(d); alloc_grant = g; credit_ret = r;
  endtask

  task automatic expect_out(input bit v, input logic [1:0] sel, input int d, input string tag);
    chk(st_valid == v, {tag, " valid"}, st_valid, v);
    chk(st_sel == sel, {tag, " sel"}, st_sel, sel);
    if (v) chk(st_data == W'(d), {tag, " data"}, st_data, d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    expect_out(1'b0, 2'b00, 0, "R1");
    chk(alloc_req == 1'b0, "R1 alloc_req", alloc_req, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    rst = 1'b0;
    tick();

    // R2 bypass sweep at an intermediate hop
    for (int i = 0; i < 16; i++) begin
      drive(1'b1, 1'b1, 8'h20 + i * 3, 1'b0, 1'b0);
      #1 chk(alloc_req == 1'b0, "R2 no request", alloc_req, 0);
      tick();
      expect_out(1'b1, 2'b01, 8'h20 + i * 3, "R2");
    end
    drive(1'b0, 1'b0, 0, 1'b0, 1'b0);
    tick();
    expect_out(1'b0, 2'b00, 0, "R2 idle");
    chk(alloc_req == 1'b0, "R2 not queued", alloc_req, 0);

    // R4/R5 normal flits queued, wait for grant, leave in order
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, 1'b0, 8'h30 + i, 1'b0, 1'b0);
      tick();
      expect_out(1'b0, 2'b00, 0, "R5 no grant");
    end
    drive(1'b0, 1'b0, 0, 1'b0, 1'b0);
    for (int i = 0; i < 2; i++) begin
      tick();
      expect_out(1'b0, 2'b00, 0, "R5 held");
      chk(alloc_req == 1'b1, "R4 request", alloc_req, 1);
    end
    alloc_grant = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      expect_out(1'b1, 2'b10, 8'h30 + i, "R4 order");
    end
    alloc_grant = 1'b0;
    tick();
    expect_out(1'b0, 2'b00, 0, "R4 drained");

    // R3 grant during a bypass has no effect
    drive(1'b1, 1'b0, 8'hA0, 1'b0, 1'b0);
    tick();
    drive(1'b1, 1'b1, 8'hB0, 1'b1, 1'b0);
    #1 chk(alloc_req == 1'b0, "R3 request masked", alloc_req, 0);
    tick();
    expect_out(1'b1, 2'b01, 8'hB0, "R3 bypass");
    drive(1'b0, 1'b0, 0, 1'b1, 1'b0);
    #1 chk(alloc_req == 1'b1, "R3 head kept", alloc_req, 1);
    tick();
    expect_out(1'b1, 2'b10, 8'hA0, "R3 later pop");
    drive(1'b0, 1'b0, 0, 1'b0, 1'b0);
    tick();

    // R10 full queue
    for (int i = 0; i < DEPTH; i++) begin
      drive(1'b1, 1'b0, 8'h40 + i, 1'b0, 1'b0);
      tick();
    end
    drive(1'b0, 1'b0, 0, 1'b0, 1'b0);
    #1 chk(in_ready == 1'b0, "R10 full normal", in_ready, 0);
    in_express = 1'b1;
    #1 chk(in_ready == 1'b1, "R10 full bypass", in_ready, 1);
    drive(1'b1, 1'b1, 8'h55, 1'b0, 1'b0);
    tick();
    expect_out(1'b1, 2'b01, 8'h55, "R10 bypass accepted");
    drive(1'b0, 1'b0, 0, 1'b1, 1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      tick();
      expect_out(1'b1, 2'b10, 8'h40 + i, "R10 drain");
    end
    alloc_grant = 1'b0;
    tick();

    // R6/R7 endpoint: express flits queued and credit gated
    cfg_endpoint = 1'b1;
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, 1'b1, 8'h60 + i, 1'b0, 1'b0);
      tick();
      expect_out(1'b0, 2'b00, 0, "R6 no bypass");
    end
    drive(1'b0, 1'b0, 0, 1'b1, 1'b0);
    tick();
    expect_out(1'b1, 2'b10, 8'h60, "R6 pop0");
    tick();
    expect_out(1'b1, 2'b10, 8'h61, "R6 pop1");
    #1 chk(alloc_req == 1'b0, "R7 no credit", alloc_req, 0);
    tick();
    expect_out(1'b0, 2'b00, 0, "R7 blocked");
    drive(1'b0, 1'b0, 0, 1'b0, 1'b1);
    tick();
    credit_ret = 1'b0;
    #1 chk(alloc_req == 1'b1, "R8 credit back", alloc_req, 1);
    alloc_grant = 1'b1;
    tick();
    expect_out(1'b1, 2'b10, 8'h62, "R8 pop after return");
    alloc_grant = 1'b0;

    // R8 saturation: 4 returns from 0 give only CRED credits
    drive(1'b0, 1'b0, 0, 1'b0, 1'b1);
    repeat (4) tick();
    credit_ret = 1'b0;
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, 1'b1, 8'h70 + i, 1'b0, 1'b0);
      tick();
    end
    drive(1'b0, 1'b0, 0, 1'b1, 1'b0);
    tick();
    expect_out(1'b1, 2'b10, 8'h70, "R8 sat pop0");
    tick();
    expect_out(1'b1, 2'b10, 8'h71, "R8 sat pop1");
    tick();
    expect_out(1'b0, 2'b00, 0, "R8 saturated");
    drive(1'b1, 1'b1, 8'h73, 1'b0, 1'b0);
    tick();
    drive(1'b0, 1'b0, 0, 1'b0, 1'b1);
    tick();
    // departure and return together: count unchanged at 1
    drive(1'b0, 1'b0, 0, 1'b1, 1'b1);
    tick();
    expect_out(1'b1, 2'b10, 8'h72, "R8 same cycle");
    drive(1'b0, 1'b0, 0, 1'b1, 1'b0);
    tick();
    expect_out(1'b1, 2'b10, 8'h73, "R8 credit kept");
    tick();
    expect_out(1'b0, 2'b00, 0, "R8 empty");

    // R9 normal flit leaves with zero express credits
    drive(1'b1, 1'b0, 8'h80, 1'b0, 1'b0);
    tick();
    drive(1'b0, 1'b0, 0, 1'b1, 1'b0);
    #1 chk(alloc_req == 1'b1, "R9 request", alloc_req, 1);
    tick();
    expect_out(1'b1, 2'b10, 8'h80, "R9 normal");
    alloc_grant = 1'b0;
    tick();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule